// File: doc/BRIEF.md
# Lookahead Occupancy FIFO

This block is a small word buffer between a microcoded processor and a serial
network port. Writes append a word at the tail. Reads come in two forms. A pop
drives the head word out and moves past it. A look drives the same word out and
leaves the buffer as it was. One pointer pair locates head and tail, and both
pointers wrap around the storage.

The consumer must often plan a few cycles ahead, so the block decodes four
active-low occupancy flags from the pointer pair. Besides empty and full, one
flag reports that at most one word is held and another that at most two are
held. Full is reported one entry short of the storage depth, which keeps the
empty and full pointer states distinct. When neither the receive side nor the
transmit side is active, both pointers return to zero, which discards any
contents.

Top module: `lookahead_fifo`

## Requirements
- R1: After reset, `empty_n`, `one_left_n` and `two_left_n` are 0, `full_n` is 1, `overrun` is 0 and `rd_data` is 0.
- R2: With occupancy n = (write pointer − read pointer) mod 16, the flag vector {empty_n, one_left_n, two_left_n, full_n} is 4'b0001 for n=0, 4'b1001 for n=1, 4'b1101 for n=2, 4'b1111 for n=3 to 14, and 4'b1110 for n=15.
- R3: A write while either side is active and the buffer is not full stores `wr_data` at the tail and advances the write pointer at that clock edge. Words leave in the order they were written.
- R4: A pop on a non-empty buffer drives the head word on `rd_data` in the same cycle and advances the read pointer at the clock edge. When pop and look are both high, the pop takes effect.
- R5: A look on a non-empty buffer drives the head word on `rd_data` and leaves the read pointer and the flags unchanged. `rd_data` is 0 when neither pop nor look is high.
- R6: Both pointers are 4 bits and wrap from 15 to 0, so order is kept across more than 16 words.
- R7: In any cycle where `rx_active` and `tx_active` are both 0, both pointers are cleared at the clock edge, writes and pops are ignored, and the flags then show the empty state.
- R8: A write to a full buffer (n=15) is dropped, and `overrun` is 1 for exactly the one cycle after that edge.
- R9: A pop or look on an empty buffer drives 0 on `rd_data` and leaves both pointers unchanged.
- R10: The flags are registered. They show the new occupancy one clock cycle after the edge that changed the pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_active | input | 1 | Receive side busy |
| tx_active | input | 1 | Transmit side busy |
| wr_en | input | 1 | Append `wr_data` at the tail |
| wr_data | input | 16 | Word to append |
| pop_en | input | 1 | Read the head word and advance |
| look_en | input | 1 | Read the head word without advancing |
| rd_data | output | 16 | Head word during pop or look, else 0 |
| empty_n | output | 1 | Low when empty |
| one_left_n | output | 1 | Low when at most one word is held |
| two_left_n | output | 1 | Low when at most two words are held |
| full_n | output | 1 | Low when 15 words are held |
| overrun | output | 1 | One-cycle pulse after a dropped write |

## Verification
The buffer is tested with several patterns. Single write-pop pairs separate the storage path from the flag path. A fill to 15 followed by an extra write shows the full decode, the dropped word and the overrun pulse. Repeated fill and drain rounds push the pointers past the wrap point, which exposes ordering faults. Looks between pops tell a read that advances from one that does not. Pops on an empty buffer, and dropping both activity inputs while words are held, confirm that the returned value is zero and that the buffer restarts from zero. The flags are sampled both one cycle and two cycles after each pointer change, which separates the registered flag timing from a combinational flag decode.

// File: rtl/lookahead_fifo_pkg.sv
package lookahead_fifo_pkg;

   typedef struct packed {
      logic empty_n;
      logic one_left_n;
      logic two_left_n;
      logic full_n;
   } occ_flags_t;

   localparam occ_flags_t FLAGS_AT_ZERO = '{empty_n: 1'b0, one_left_n: 1'b0,
                                            two_left_n: 1'b0, full_n: 1'b1};

endpackage

// File: rtl/lookahead_fifo_ptrs.sv
module lookahead_fifo_ptrs #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr_go,
   input  logic              rd_go,
   output logic [ADDR_W-1:0] wptr,
   output logic [ADDR_W-1:0] rptr,
   output logic [ADDR_W-1:0] occ
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else if (clear) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (wr_go) wptr <= wptr + 1'b1;
         if (rd_go) rptr <= rptr + 1'b1;
      end
   end

   assign occ = wptr - rptr;

endmodule

// File: rtl/lookahead_fifo_store.sv
module lookahead_fifo_store #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/lookahead_fifo_flags.sv
module lookahead_fifo_flags
   import lookahead_fifo_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter bit REG_FLAGS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] occ,
   output occ_flags_t        flags
);

   occ_flags_t decoded;

   always_comb begin
      decoded.empty_n    = (occ != '0);
      decoded.one_left_n = (occ > ADDR_W'(1));
      decoded.two_left_n = (occ > ADDR_W'(2));
      decoded.full_n     = (occ != {ADDR_W{1'b1}});
   end

   generate
      if (REG_FLAGS) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags <= FLAGS_AT_ZERO;
            else        flags <= decoded;
         end
      end else begin : g_comb
         assign flags = decoded;
      end
   endgenerate

endmodule

// File: rtl/lookahead_fifo.sv
module lookahead_fifo
   import lookahead_fifo_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 16,
   parameter bit REG_FLAGS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_active,
   input  logic              tx_active,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pop_en,
   input  logic              look_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty_n,
   output logic              one_left_n,
   output logic              two_left_n,
   output logic              full_n,
   output logic              overrun
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("lookahead_fifo: ADDR_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("lookahead_fifo: DATA_W must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] wptr, rptr, occ;
   logic [DATA_W-1:0] head;
   logic              clear, is_empty, is_full, wr_go, rd_go;
   occ_flags_t        flags;

   assign clear    = !(rx_active || tx_active);
   assign is_empty = (occ == '0);
   assign is_full  = (occ == {ADDR_W{1'b1}});
   assign wr_go    = wr_en && !is_full && !clear;
   assign rd_go    = pop_en && !is_empty && !clear;

   lookahead_fifo_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .wr_go (wr_go),
      .rd_go (rd_go),
      .wptr  (wptr),
      .rptr  (rptr),
      .occ   (occ)
   );

   lookahead_fifo_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .we    (wr_go),
      .waddr (wptr),
      .wdata (wr_data),
      .raddr (rptr),
      .rdata (head)
   );

   lookahead_fifo_flags #(.ADDR_W(ADDR_W), .REG_FLAGS(REG_FLAGS)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .occ   (occ),
      .flags (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) overrun <= 1'b0;
      else        overrun <= wr_en && is_full && !clear;
   end

   assign rd_data    = ((pop_en || look_en) && !is_empty) ? head : '0;
   assign empty_n    = flags.empty_n;
   assign one_left_n = flags.one_left_n;
   assign two_left_n = flags.two_left_n;
   assign full_n     = flags.full_n;

endmodule

// File: rtl/lookahead_fifo_chk.sv
module lookahead_fifo_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_active,
   input logic              tx_active,
   input logic              wr_en,
   input logic              pop_en,
   input logic              look_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              empty_n,
   input logic              one_left_n,
   input logic              two_left_n,
   input logic              full_n,
   input logic              overrun,
   input logic [ADDR_W-1:0] wptr,
   input logic [ADDR_W-1:0] rptr
);

   logic              busy;
   logic [ADDR_W-1:0] wptr_inc, rptr_inc, held;

   assign busy     = rx_active || tx_active;
   assign wptr_inc = wptr + 1'b1;
   assign rptr_inc = rptr + 1'b1;
   assign held     = wptr - rptr;

   AST_FLAG_NEST: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n |-> !one_left_n) and (!one_left_n |-> !two_left_n)); // R2
   AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> (empty_n && two_left_n)); // R2
   AST_WRITE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy && held != {ADDR_W{1'b1}}) |=> wptr == $past(wptr_inc)); // R3
   AST_POP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_en && busy && held != '0) |=> rptr == $past(rptr_inc)); // R4
   AST_LOOK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (look_en && !pop_en && busy) |=> rptr == $past(rptr)); // R5
   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (wptr == '0 && rptr == '0)); // R7
   AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(wr_en)); // R8
   AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (held == '0 && (pop_en || look_en)) |-> rd_data == '0); // R9

endmodule

bind lookahead_fifo lookahead_fifo_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_active  (rx_active),
   .tx_active  (tx_active),
   .wr_en      (wr_en),
   .pop_en     (pop_en),
   .look_en    (look_en),
   .rd_data    (rd_data),
   .empty_n    (empty_n),
   .one_left_n (one_left_n),
   .two_left_n (two_left_n),
   .full_n     (full_n),
   .overrun    (overrun),
   .wptr       (wptr),
   .rptr       (rptr)
);

// File: tb/lookahead_fifo_test.sv
`timescale 1ns/1ps
module lookahead_fifo_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_active = 1'b1, tx_active = 1'b0;
   logic        wr_en = 1'b0, pop_en = 1'b0, look_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        empty_n, one_left_n, two_left_n, full_n, overrun;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   logic [15:0] sb[$];

   always #10 clk = ~clk;

   lookahead_fifo uut (
      .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .tx_active(tx_active),
      .wr_en(wr_en), .wr_data(wr_data), .pop_en(pop_en), .look_en(look_en),
      .rd_data(rd_data), .empty_n(empty_n), .one_left_n(one_left_n),
      .two_left_n(two_left_n), .full_n(full_n), .overrun(overrun)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // driver: one cycle of stimulus, scoreboard updated from the requirements
   task automatic drive(input logic w, input logic [15:0] d, input logic p,
                        input logic l);
      @(negedge clk);
      wr_en = w; wr_data = d; pop_en = p; look_en = l;
      if (w && sb.size() < 15) sb.push_back(d);
   endtask

   task automatic idle();
      @(negedge clk);
      wr_en = 1'b0; pop_en = 1'b0; look_en = 1'b0;
   endtask

   function automatic logic [3:0] exp_flags(input int n);
      return {n != 0, n > 1, n > 2, n != 15};
   endfunction

   task automatic chk_flags(input string tag);
      @(negedge clk);
      #5;
      chk({empty_n, one_left_n, two_left_n, full_n} === exp_flags(sb.size()), tag,
          {empty_n, one_left_n, two_left_n, full_n}, exp_flags(sb.size()));
   endtask

   // monitor: compares the head word while a read is requested
   always @(negedge clk) begin
      #5;
      if (rst_n && (pop_en || look_en)) begin
         if (sb.size() == 0) begin
            chk(rd_data === 16'h0, "R9 read on empty", rd_data, 0);
         end else begin
            chk(rd_data === sb[0], pop_en ? "R4 pop head" : "R5 look head",
                rd_data, sb[0]);
            if (pop_en) void'(sb.pop_front());
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #5;
      chk({empty_n, one_left_n, two_left_n, full_n, overrun} === 5'b00010,
          "R1 reset flags", {empty_n, one_left_n, two_left_n, full_n, overrun}, 5'b00010);
      chk(rd_data === 16'h0, "R1 reset data", rd_data, 0);
      @(negedge clk);
      rst_n = 1'b1;
      chk_flags("R1 flags after release");

      // R9: pop and look on empty
      drive(0, 0, 1, 0);
      drive(0, 0, 0, 1);
      idle();
      chk_flags("R9 flags unchanged");

      // R10: flags lag one cycle
      drive(1, 16'hA001, 0, 0);
      idle();
      #5;
      chk(empty_n === 1'b0, "R10 flag still old", empty_n, 0);
      chk_flags("R10 flag updated");
      chk_flags("R2 one word");

      // R5: look keeps head; R3/R2 two and three words
      drive(1, 16'hA002, 0, 0);
      idle();
      chk_flags("R2 two words");
      drive(1, 16'hA003, 0, 0);
      drive(0, 0, 0, 1);
      drive(0, 0, 0, 1);
      idle();
      chk_flags("R5 look leaves flags");
      drive(0, 0, 1, 1);     // R4: pop wins over look
      drive(1, 16'hA004, 1, 0); // write and pop together
      idle();
      chk_flags("R3 simultaneous write and pop");
      drive(0, 0, 1, 0);
      drive(0, 0, 1, 0);
      idle();
      chk_flags("R4 drained");

      // R6 and R8: three fill-drain rounds crossing the wrap point
      for (int r = 0; r < 3; r++) begin
         for (int i = 0; i < 15; i++) drive(1, 16'(r * 256 + i + 16'h100), 0, 0);
         idle();
         chk_flags("R2 full at 15");
         drive(1, 16'hDEAD, 0, 0);
         idle();
         #5;
         chk(overrun === 1'b1, "R8 overrun pulse", overrun, 1);
         @(negedge clk);
         #5;
         chk(overrun === 1'b0, "R8 pulse one cycle", overrun, 0);
         chk_flags("R8 still full");
         for (int i = 0; i < 15; i++) drive(0, 0, 1, 0);
         idle();
         chk_flags("R6 drained after wrap");
      end

      // R7: idle clear discards content
      for (int i = 0; i < 5; i++) drive(1, 16'(16'h700 + i), 0, 0);
      idle();
      chk_flags("R2 five words");
      @(negedge clk);
      rx_active = 1'b0;
      @(negedge clk);
      tx_active = 1'b1;
      sb.delete();
      chk_flags("R7 cleared");
      drive(1, 16'h7777, 0, 0);
      drive(0, 0, 1, 0);
      idle();
      chk_flags("R7 restart");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule